// File: doc/BRIEF.md
# Keyed index/data configuration port with banked device registers

This block is the device end of a two-address configuration window on a host byte bus. One address (the index port, at the parameter `BASE`) holds a register number, and the address directly above it (the data port) reads or writes the register that number names. The whole window stays locked after reset. It opens only after a fixed key byte has been written to the index port twice in a row, and a separate exit byte written to the index port locks it again.

The register space has two parts. Index values below `DEV_LO` (0x30) are global. They hold a device-select register at 0x07 and a read-only 16-bit identity value, with its upper byte at 0x20 and its lower byte at 0x21. Index values from `DEV_LO` upward belong to the register bank of the logical device that the device-select register currently names. Accesses there are passed on to child banks through a simple strobe interface. A child that implements the addressed register raises `bank_hit`. Where no child answers, a read returns 0x00 and a write is dropped.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the window is locked, the index register holds 0x00 and the device-select register holds 0x00.
- R2: The window opens only when the key byte 0x87 is written to the index port on two consecutive index-port writes. Any other index-port value written after the first key byte returns the sequence to its start. Data-port accesses do not affect the sequence.
- R3: While the window is locked, data-port writes change no register and raise no `bank_wr`, and reads of either port return 0xFF.
- R4: While open, writing 0xAA to the index port locks the window and leaves the index register unchanged. The device-select register keeps its value across lock and unlock.
- R5: While open, global register 0x20 reads 0x10 and register 0x21 reads 0x61 (identity value 0x1061). Writes to them are ignored.
- R6: While open, global register 0x07 reads back the last byte written to it, and its value appears on `bank_ldn`.
- R7: While open with index >= 0x30, a data-port read returns `bank_rdata` and pulses `bank_rd`. A data-port write whose `bank_hit` is high pulses `bank_wr` in the same cycle with `bank_ldn`, `bank_idx` and `bank_wdata` set to the device select, the index and the written byte.
- R8: An index the selected device does not implement reads 0x00 and discards writes. This covers global indices other than 0x07, 0x20 and 0x21, and device indices with `bank_hit` low, which raise no `bank_wr`.
- R9: `io_rdata` takes the read value on the clock edge that ends a port read cycle. It holds that value until the next read of either port.
- R10: Bus accesses to any address other than `BASE` and `BASE`+1 have no effect on state, on `io_rdata` or on the bank strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | Host write strobe, one cycle per write |
| io_rd | input | 1 | Host read strobe, one cycle per read |
| io_addr | input | AW | Host I/O address |
| io_wdata | input | 8 | Host write byte |
| io_rdata | output | 8 | Registered read byte |
| bank_ldn | output | 8 | Currently selected logical device |
| bank_idx | output | 8 | Current register index |
| bank_wr | output | 1 | Write strobe to the selected device bank |
| bank_rd | output | 1 | Read strobe to the selected device bank |
| bank_wdata | output | 8 | Byte written to the device bank |
| bank_rdata | input | 8 | Byte returned by the device bank |
| bank_hit | input | 1 | The selected device implements `bank_idx` |

## Verification
The main read path is swept over every index except the exit byte, for four device selections. Against a bench bank model that answers only some devices in the upper index range, this tells apart global decode, identity bytes, device-select readback, forwarded data and the 0x00 default. Key sequences are tried whole, broken by a foreign byte, interleaved with data-port writes, and sent to a wrong address, which separates a correct two-in-a-row unlock from a counter or a loose address decode. Writes are sent to a hit bank, a missed bank, a global hole and the identity bytes, and the bench counts `bank_wr` strobes to show which writes were forwarded and which were dropped.

// File: rtl/sio_cfg_port.sv
module sio_cfg_port #(
  parameter int AW = 8,
  parameter logic [AW-1:0] BASE = 8'h2E,
  parameter logic [7:0] KEY = 8'h87,
  parameter logic [7:0] EXIT = 8'hAA,
  parameter logic [7:0] LDN_IDX = 8'h07,
  parameter logic [7:0] ID_HI_IDX = 8'h20,
  parameter logic [15:0] CHIP_ID = 16'h1061,
  parameter logic [7:0] DEV_LO = 8'h30
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          io_wr,
  input  logic          io_rd,
  input  logic [AW-1:0] io_addr,
  input  logic [7:0]    io_wdata,
  output logic [7:0]    io_rdata,
  output logic [7:0]    bank_ldn,
  output logic [7:0]    bank_idx,
  output logic          bank_wr,
  output logic          bank_rd,
  output logic [7:0]    bank_wdata,
  input  logic [7:0]    bank_rdata,
  input  logic          bank_hit
);
  localparam logic [AW-1:0] DATA_ADDR = BASE + AW'(1);
  localparam logic [7:0] ID_LO_IDX = ID_HI_IDX + 8'd1;

  typedef enum logic [1:0] {ST_LOCKED, ST_KEY1, ST_OPEN} st_t;
  st_t st;

  logic [7:0] idx_r, ldn_r, glb_val, rd_val;
  logic idx_sel, dat_sel, cfg_open, dev_space;

  assign idx_sel   = io_addr == BASE;
  assign dat_sel   = io_addr == DATA_ADDR;
  assign cfg_open  = st == ST_OPEN;
  assign dev_space = idx_r >= DEV_LO;

  assign bank_ldn   = ldn_r;
  assign bank_idx   = idx_r;
  assign bank_wdata = io_wdata;
  assign bank_wr    = cfg_open && io_wr && dat_sel && dev_space && bank_hit;
  assign bank_rd    = cfg_open && io_rd && dat_sel && dev_space;

  always_comb begin
    if (idx_r == LDN_IDX)        glb_val = ldn_r;
    else if (idx_r == ID_HI_IDX) glb_val = CHIP_ID[15:8];
    else if (idx_r == ID_LO_IDX) glb_val = CHIP_ID[7:0];
    else                         glb_val = 8'h00;
  end

  always_comb begin
    if (!cfg_open)      rd_val = 8'hFF;
    else if (idx_sel)   rd_val = idx_r;
    else if (dev_space) rd_val = bank_hit ? bank_rdata : 8'h00;
    else                rd_val = glb_val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= ST_LOCKED;
      idx_r <= 8'h00;
      ldn_r <= 8'h00;
    end else begin
      if (io_wr && idx_sel) begin
        case (st)
          ST_LOCKED: st <= (io_wdata == KEY) ? ST_KEY1 : ST_LOCKED;
          ST_KEY1:   st <= (io_wdata == KEY) ? ST_OPEN : ST_LOCKED;
          default: begin
            if (io_wdata == EXIT) st <= ST_LOCKED;
            else                  idx_r <= io_wdata;
          end
        endcase
      end
      if (cfg_open && io_wr && dat_sel && idx_r == LDN_IDX)
        ldn_r <= io_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) io_rdata <= 8'h00;
    else if (io_rd && (idx_sel || dat_sel)) io_rdata <= rd_val;
  end
endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk #(
  parameter int AW = 8,
  parameter logic [AW-1:0] BASE = 8'h2E,
  parameter logic [7:0] KEY = 8'h87,
  parameter logic [7:0] EXIT = 8'hAA,
  parameter logic [7:0] DEV_LO = 8'h30
) (
  input logic          clk,
  input logic          rst_n,
  input logic          io_wr,
  input logic          io_rd,
  input logic [AW-1:0] io_addr,
  input logic [7:0]    io_wdata,
  input logic [7:0]    io_rdata,
  input logic [7:0]    bank_idx,
  input logic          bank_wr,
  input logic          bank_rd,
  input logic          bank_hit,
  input logic          cfg_open
);
  localparam logic [AW-1:0] DATA_ADDR = BASE + AW'(1);

  a_r3_no_bank_wr_locked: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_open |-> !bank_wr && !bank_rd);

  a_r3_locked_read_ff: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_open && io_rd && (io_addr == DATA_ADDR)) |=> io_rdata == 8'hFF);

  a_r2_open_after_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_open) |-> $past(io_wr && io_addr == BASE && io_wdata == KEY));

  a_r4_exit_locks: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_open && io_wr && io_addr == BASE && io_wdata == EXIT) |=> !cfg_open);

  a_r8_bank_wr_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    bank_wr |-> bank_hit && bank_idx >= DEV_LO);

  a_r9_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_rd && (io_addr == BASE || io_addr == DATA_ADDR)) |=> $stable(io_rdata));
endmodule

bind sio_cfg_port sio_cfg_port_chk #(.AW(AW), .BASE(BASE), .KEY(KEY), .EXIT(EXIT), .DEV_LO(DEV_LO)) chk_i (
  .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
  .io_wdata(io_wdata), .io_rdata(io_rdata), .bank_idx(bank_idx), .bank_wr(bank_wr),
  .bank_rd(bank_rd), .bank_hit(bank_hit), .cfg_open(cfg_open)
);

// File: tb/sio_cfg_port_tb_top.sv
`timescale 1ns/1ps
module sio_cfg_port_tb_top;
  localparam logic [7:0] BASE = 8'h2E;
  localparam logic [7:0] DATA = 8'h2F;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0] io_addr = 8'h00, io_wdata = 8'h00;
  logic [7:0] io_rdata, bank_ldn, bank_idx, bank_wdata, bank_rdata;
  logic bank_wr, bank_rd, bank_hit;

  int checks = 0, errors = 0, wr_count = 0;
  logic [7:0] last_ldn, last_idx, last_data;
  logic [7:0] got;

  always #2.5 clk = ~clk;

  sio_cfg_port dut_i (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .bank_ldn(bank_ldn), .bank_idx(bank_idx),
    .bank_wr(bank_wr), .bank_rd(bank_rd), .bank_wdata(bank_wdata),
    .bank_rdata(bank_rdata), .bank_hit(bank_hit)
  );

  // child bank model: devices 0..2 implement indices 0xE0..0xFF
  assign bank_hit   = (bank_ldn < 8'd3) && (bank_idx >= 8'hE0);
  assign bank_rdata = 8'((int'(bank_ldn) * 37 + int'(bank_idx)) & 255);

  always @(posedge clk) begin
    if (bank_wr) begin
      wr_count  <= wr_count + 1;
      last_ldn  <= bank_ldn;
      last_idx  <= bank_idx;
      last_data <= bank_wdata;
    end
  end

  function automatic logic [7:0] model_rd(input int ldn, input int idx);
    if (idx < 8'h30) begin
      if (idx == 8'h07) return 8'(ldn);
      if (idx == 8'h20) return 8'h10;
      if (idx == 8'h21) return 8'h61;
      return 8'h00;
    end
    if (ldn < 3 && idx >= 8'hE0) return 8'((ldn * 37 + idx) & 255);
    return 8'h00;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); io_addr = a; io_rd = 1'b1;
    @(negedge clk); io_rd = 1'b0; d = io_rdata;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic unlock();
    wr(BASE, 8'h87); wr(BASE, 8'h87);
  endtask

  task automatic reg_rd(input logic [7:0] idx, output logic [7:0] d);
    wr(BASE, idx); rd(DATA, d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 rdata after reset", io_rdata, 8'h00);
    rd(DATA, got); chk("R3 locked data read", got, 8'hFF);
    rd(BASE, got); chk("R3 locked index read", got, 8'hFF);
    // locked data write is ignored
    wr(DATA, 8'h55);
    chk("R3 locked write no bank_wr", wr_count, 0);
    // broken sequence, with a data write in the middle of a good one
    wr(BASE, 8'h87); wr(BASE, 8'h12); wr(BASE, 8'h87);
    rd(DATA, got); chk("R2 broken key stays locked", got, 8'hFF);
    wr(DATA, 8'h00);
    wr(BASE, 8'h87);
    rd(BASE, got); chk("R1 index reset value after unlock R2", got, 8'h00);
    reg_rd(8'h07, got); chk("R1 ldn reset and R3 locked write dropped", got, 8'h00);
    // identity bytes, read-only
    reg_rd(8'h20, got); chk("R5 id high", got, 8'h10);
    reg_rd(8'h21, got); chk("R5 id low", got, 8'h61);
    wr(DATA, 8'hEE);
    reg_rd(8'h21, got); chk("R5 id low write ignored", got, 8'h61);
    // device select
    wr(BASE, 8'h07); wr(DATA, 8'hC5);
    rd(DATA, got); chk("R6 ldn readback", got, 8'hC5);
    chk("R6 ldn on port", bank_ldn, 8'hC5);
    // sweep every index for four devices
    for (int l = 0; l < 4; l++) begin
      wr(BASE, 8'h07); wr(DATA, 8'(l));
      for (int i = 0; i < 256; i++) begin
        if (i == 8'hAA) continue;
        reg_rd(8'(i), got);
        chk((i >= 8'h30) ? "R7 R8 device read" : "R8 R5 R6 global read", got, model_rd(l, i));
      end
    end
    // forwarded write to a hit bank
    wr(BASE, 8'h07); wr(DATA, 8'h01);
    wr(BASE, 8'hE5); wr(DATA, 8'h3C);
    chk("R7 bank_wr count", wr_count, 1);
    chk("R7 bank_wr ldn", last_ldn, 8'h01);
    chk("R7 bank_wr idx", last_idx, 8'hE5);
    chk("R7 bank_wr data", last_data, 8'h3C);
    // missed bank and global hole
    wr(BASE, 8'h40); wr(DATA, 8'h77);
    chk("R8 miss no bank_wr", wr_count, 1);
    wr(BASE, 8'h07); wr(DATA, 8'h03);
    wr(BASE, 8'hE5); wr(DATA, 8'h77);
    chk("R8 unimplemented device no bank_wr", wr_count, 1);
    wr(BASE, 8'h25); wr(DATA, 8'h99);
    rd(DATA, got); chk("R8 global hole reads zero", got, 8'h00);
    // read hold
    reg_rd(8'h20, got);
    wr(BASE, 8'h21); wr(DATA, 8'h00);
    repeat (3) @(negedge clk);
    chk("R9 rdata held", io_rdata, 8'h10);
    rd(BASE, got); chk("R9 index port read", got, 8'h21);
    // foreign address
    rd(8'h4E, got); chk("R10 foreign read leaves rdata", io_rdata, 8'h21);
    wr(8'h4E, 8'hAA); wr(8'h30, 8'h07);
    rd(BASE, got); chk("R10 foreign write no effect", got, 8'h21);
    // exit and re-entry
    wr(BASE, 8'hAA);
    rd(DATA, got); chk("R4 exit locks", got, 8'hFF);
    wr(8'h4E, 8'h87); wr(8'h4E, 8'h87);
    rd(DATA, got); chk("R10 key at foreign address", got, 8'hFF);
    unlock();
    rd(BASE, got); chk("R4 index kept over exit", got, 8'h21);
    reg_rd(8'h07, got); chk("R4 ldn kept over exit", got, 8'h03);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule